// File: doc/BRIEF.md
# UART Line Status Word Logic

This block keeps the 8-bit line status byte of a UART in one place. The UART has two modes: a single-character holding mode and a FIFO mode. The receiver sends one-cycle event pulses for a parity error, a framing error, a break and an overrun. It also drives a level that shows whether any received character is waiting. The transmitter drives two levels. One says that its holding stage (or its transmit FIFO, in FIFO mode) is empty. The other says that its shift register is idle. The CPU reads the status address with a one-cycle strobe.

The error flags are sticky. Each one stays set until the CPU reads the byte. The read returns the value held before the clear, and the clear takes effect on the clock edge after the strobe. If a new error pulse arrives in the same cycle as the read, that flag stays set, so the event is not lost.

In FIFO mode an extra summary bit collects parity, framing and break events. In character mode the summary bit always reads 0. The data-ready bit follows the receiver's level, so it can rise before the stop bit of the frame has been sampled. Software should allow one stop-bit time before it reads the data.

Top module: `line_status_unit`

## Requirements
- R1: After a synchronous active-low reset, `status_o` reads 0x60: bits 6 and 5 are set and all other bits are clear, whatever the inputs are.
- R2: A one-cycle pulse on the break, framing, parity or overrun input sets status bit 4, 3, 2 or 1 respectively, one edge later. The bit then stays set on later cycles until a read.
- R3: A read strobe returns the current byte unchanged in its own cycle. On the following edge it clears bits 7 and 4 down to 1.
- R4: An error pulse in the same cycle as a read strobe leaves its flag set after the clearing edge.
- R5: With `fifo_mode_i` = 1, a parity, framing or break pulse sets bit 7 one edge later, and bit 7 is sticky until a read. An overrun pulse alone does not set bit 7.
- R6: With `fifo_mode_i` = 0 at an edge, bit 7 is 0 after that edge. This holds even if an error pulse arrives at the same edge, or if bit 7 was set before.
- R7: Bit 5 equals `tx_hold_empty_i` as sampled at the previous edge. Its meaning depends on the mode: in character mode it says the held character has moved to the shifter; in FIFO mode it says the transmit FIFO is empty.
- R8: Bit 6 is 1 one edge after both `tx_hold_empty_i` and `tx_shift_idle_i` are 1, and 0 one edge after either of them is 0.
- R9: Bit 0 equals `rx_data_present_i` as sampled at the previous edge. It is not cleared by a read.
- R10: A read strobe has no effect on bits 0, 5 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic and inputs |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_mode_i | input | 1 | 1 = FIFO mode, 0 = single-character mode |
| rx_parity_err_i | input | 1 | One-cycle pulse: parity error on a received character |
| rx_frame_err_i | input | 1 | One-cycle pulse: missing stop bit |
| rx_break_i | input | 1 | One-cycle pulse: break condition seen on the line |
| rx_overrun_i | input | 1 | One-cycle pulse: unread character overwritten |
| rx_data_present_i | input | 1 | Level: received data is waiting |
| tx_hold_empty_i | input | 1 | Level: transmit holding stage or FIFO is empty |
| tx_shift_idle_i | input | 1 | Level: transmit shift register holds no data |
| status_rd_i | input | 1 | One-cycle pulse: CPU reads the status byte |
| status_o | output | 8 | Line status byte |

## Verification
Every bit of `status_o` comes from a register. A pulse or level applied in one cycle therefore shows at the port one edge later, and the effect of a read also appears one edge after the strobe. The driver changes inputs on the falling edge and queues the byte it expects after the next rising edge. The monitor compares on the falling edge that follows, so each comparison lands exactly one edge after its stimulus. The byte returned by a read is the byte the monitor checked in the strobe cycle, and the clear is checked one comparison later.

// File: rtl/lsr_pkg.sv
// Package: bit positions and widths for the UART line status byte.
// Assumes: one clock domain; every bit of the byte is registered.
package lsr_pkg;
    localparam int STATUS_W     = 8;
    localparam int NUM_ERR_FLAGS = 4;   // break, framing, parity, overrun

    // Bit positions (decoded by software, so they are fixed).
    localparam int BIT_RDY      = 0;
    localparam int BIT_OVR      = 1;    // first sticky error flag
    localparam int BIT_PAR      = 2;
    localparam int BIT_FRM      = 3;
    localparam int BIT_BRK      = 4;
    localparam int BIT_HOLD_MT  = 5;
    localparam int BIT_ALL_MT   = 6;
    localparam int BIT_ERR_SUM  = 7;

    localparam logic [STATUS_W-1:0] STATUS_RESET = 8'h60;

    typedef enum logic {
        MODE_CHAR = 1'b0,
        MODE_FIFO = 1'b1
    } uart_mode_e;
endpackage

// File: rtl/lsr_sticky_flag.sv
// Module: one sticky error flag, set by an event pulse and cleared by a read.
// Assumes: rd_i is a one-cycle strobe. An event in the read cycle wins over
// the clear, so no event is lost.
module lsr_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic rd_i,
    output logic flag_o
);
    // Purpose: keep the flag; set wins over clear-on-read.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (evt_i) flag_o <= 1'b1;
        else if (rd_i)  flag_o <= 1'b0;
    end

    AST_FLAG_SETS:  assert property (@(posedge clk) disable iff (!rst_n) evt_i |=> flag_o);               // R2
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (flag_o && !rd_i) |=> flag_o);   // R2
    AST_FLAG_CLRS:  assert property (@(posedge clk) disable iff (!rst_n) (rd_i && !evt_i) |=> !flag_o);   // R3
    AST_FLAG_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) (rd_i && evt_i) |=> flag_o);     // R4
endmodule

// File: rtl/lsr_err_summary.sv
// Module: FIFO-mode error summary bit. Set by a parity, framing or break event.
// Cleared by a read. Held at 0 whenever character mode is selected.
// Assumes: err_evt_i holds the error pulses that count toward the summary.
module lsr_err_summary #(
    parameter int N_SRC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_mode_i,
    input  logic [N_SRC-1:0] err_evt_i,
    input  logic             rd_i,
    output logic             sum_o
);
    logic any_evt;

    // Purpose: merge the contributing error pulses.
    always_comb any_evt = |err_evt_i;

    // Purpose: keep the summary; forced to 0 in character mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                          sum_o <= 1'b0;
        else if (fifo_mode_i != 1'b1)        sum_o <= 1'b0;
        else if (any_evt)                    sum_o <= 1'b1;
        else if (rd_i)                       sum_o <= 1'b0;
    end

    AST_SUM_CHAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !fifo_mode_i |=> !sum_o);                 // R6
    AST_SUM_SETS:      assert property (@(posedge clk) disable iff (!rst_n) (fifo_mode_i && any_evt) |=> sum_o);       // R5
    AST_SUM_CLRS:      assert property (@(posedge clk) disable iff (!rst_n) (rd_i && !any_evt) |=> !sum_o);            // R3
endmodule

// File: rtl/lsr_tx_status.sv
// Module: registers the two transmit-empty bits.
// Assumes: the transmitter drives the levels in the meaning of the current mode
// (holding stage in character mode, transmit FIFO in FIFO mode).
module lsr_tx_status (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_empty_i,
    input  logic shift_idle_i,
    output logic hold_empty_o,
    output logic all_empty_o
);
    // Purpose: sample both levels; reset shows the transmitter as empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_empty_o <= 1'b1;
            all_empty_o  <= 1'b1;
        end else begin
            hold_empty_o <= hold_empty_i;
            all_empty_o  <= hold_empty_i & shift_idle_i;
        end
    end

    AST_HOLD_SET:  assert property (@(posedge clk) disable iff (!rst_n) hold_empty_i |=> hold_empty_o);                   // R7
    AST_HOLD_CLR:  assert property (@(posedge clk) disable iff (!rst_n) !hold_empty_i |=> !hold_empty_o);                 // R7
    AST_ALL_NEEDS: assert property (@(posedge clk) disable iff (!rst_n) !(hold_empty_i && shift_idle_i) |=> !all_empty_o); // R8
    AST_ALL_IMPL:  assert property (@(posedge clk) disable iff (!rst_n) all_empty_o |-> hold_empty_o);                    // R8
endmodule

// File: rtl/line_status_unit.sv
// Module: top of the UART line status byte. Combines the sticky receive-error
// flags, the FIFO error summary, the transmit-empty bits and data-ready.
// Assumes: all inputs are synchronous to clk; the error inputs and status_rd_i
// are one-cycle pulses; every status bit is registered (one edge of latency).
module line_status_unit
    import lsr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fifo_mode_i,
    input  logic                rx_parity_err_i,
    input  logic                rx_frame_err_i,
    input  logic                rx_break_i,
    input  logic                rx_overrun_i,
    input  logic                rx_data_present_i,
    input  logic                tx_hold_empty_i,
    input  logic                tx_shift_idle_i,
    input  logic                status_rd_i,
    output logic [STATUS_W-1:0] status_o
);
    localparam int SUM_SRC = NUM_ERR_FLAGS - 1;   // overrun does not count

    logic [NUM_ERR_FLAGS-1:0] err_evt;   // index 0 = overrun ... 3 = break
    logic [NUM_ERR_FLAGS-1:0] err_flag;
    logic                     err_sum;
    logic                     hold_mt;
    logic                     all_mt;
    logic                     rdy_q;

    // Purpose: order the error pulses to match their bit positions 1..4.
    always_comb err_evt = {rx_break_i, rx_frame_err_i, rx_parity_err_i, rx_overrun_i};

    // One sticky flag for each error bit.
    for (genvar g = 0; g < NUM_ERR_FLAGS; g++) begin : g_flag
        lsr_sticky_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt_i  (err_evt[g]),
            .rd_i   (status_rd_i),
            .flag_o (err_flag[g])
        );
    end

    lsr_err_summary #(.N_SRC(SUM_SRC)) u_sum (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_mode_i (fifo_mode_i == MODE_FIFO),
        .err_evt_i   (err_evt[NUM_ERR_FLAGS-1:1]),
        .rd_i        (status_rd_i),
        .sum_o       (err_sum)
    );

    lsr_tx_status u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .hold_empty_i (tx_hold_empty_i),
        .shift_idle_i (tx_shift_idle_i),
        .hold_empty_o (hold_mt),
        .all_empty_o  (all_mt)
    );

    // Purpose: follow the receiver's data level; a read does not clear it.
    always_ff @(posedge clk) begin
        if (!rst_n) rdy_q <= 1'b0;
        else        rdy_q <= rx_data_present_i;
    end

    // Purpose: assemble the byte from the registered bits.
    always_comb begin
        status_o                      = '0;
        status_o[BIT_RDY]             = rdy_q;
        status_o[BIT_BRK:BIT_OVR]     = err_flag;
        status_o[BIT_HOLD_MT]         = hold_mt;
        status_o[BIT_ALL_MT]          = all_mt;
        status_o[BIT_ERR_SUM]         = err_sum;
    end

    AST_RDY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) rx_data_present_i |=> status_o[BIT_RDY]);   // R9
    AST_RDY_DROPS:   assert property (@(posedge clk) disable iff (!rst_n) !rx_data_present_i |=> !status_o[BIT_RDY]); // R9
    AST_RD_KEEPS_TX: assert property (@(posedge clk) disable iff (!rst_n)
                         (status_rd_i && $stable(tx_hold_empty_i) && $stable(tx_shift_idle_i))
                         |=> $stable(status_o[BIT_ALL_MT:BIT_HOLD_MT]));                                            // R10
    AST_OVR_NO_SUM:  assert property (@(posedge clk) disable iff (!rst_n)
                         (rx_overrun_i && !rx_parity_err_i && !rx_frame_err_i && !rx_break_i && !err_sum && status_rd_i)
                         |=> !status_o[BIT_ERR_SUM]);                                                               // R5
endmodule

// File: tb/line_status_unit_bench.sv
// Scoreboard bench: the driver queues the byte expected one edge after each
// stimulus; the monitor compares on the next falling edge.
module line_status_unit_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode = 1'b0, par = 1'b0, frm = 1'b0, brk = 1'b0, ovr = 1'b0;
    logic avail = 1'b0, hold = 1'b1, idle = 1'b1, rd = 1'b0;
    logic [7:0] status;

    typedef struct {
        logic [7:0] val;
        string      req;
    } exp_t;
    exp_t q[$];

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference state, written from the requirements.
    logic [3:0] m_err = '0;    // index 0 = overrun(bit1) ... 3 = break(bit4)
    logic m_sum = 1'b0, m_rdy = 1'b0, m_hmt = 1'b1, m_amt = 1'b1;

    always #2 clk = ~clk;   // 250 MHz

    line_status_unit u_line_status_unit (
        .clk(clk), .rst_n(rst_n), .fifo_mode_i(mode),
        .rx_parity_err_i(par), .rx_frame_err_i(frm), .rx_break_i(brk),
        .rx_overrun_i(ovr), .rx_data_present_i(avail),
        .tx_hold_empty_i(hold), .tx_shift_idle_i(idle),
        .status_rd_i(rd), .status_o(status)
    );

    function automatic logic [7:0] model_byte();
        return {m_sum, m_amt, m_hmt, m_err[3], m_err[2], m_err[1], m_err[0], m_rdy};
    endfunction

    // Driver: apply one cycle of stimulus and queue the byte due after the edge.
    task automatic step(input logic md, input logic p, input logic f, input logic b,
                        input logic o, input logic av, input logic h, input logic i,
                        input logic r, input string req);
        logic [3:0] ev;
        @(negedge clk);
        mode = md; par = p; frm = f; brk = b; ovr = o;
        avail = av; hold = h; idle = i; rd = r;
        ev = {b, f, p, o};
        m_err = (m_err & ~{4{r}}) | ev;
        if (!md)              m_sum = 1'b0;
        else if (p | f | b)   m_sum = 1'b1;
        else if (r)           m_sum = 1'b0;
        m_rdy = av;
        m_hmt = h;
        m_amt = h & i;
        @(posedge clk);
        #1;
        q.push_back('{model_byte(), req});
        par = 1'b0; frm = 1'b0; brk = 1'b0; ovr = 1'b0; rd = 1'b0;
    endtask

    // Monitor: compare the due byte on the falling edge.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (status !== e.val) begin
                n_bad++;
                $display("FAIL %s: status=0x%02h expected=0x%02h", e.req, status, e.val);
            end
        end
    end

    // Watchdog.
    initial begin
        #800000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset with unfriendly inputs still gives 0x60.
        hold = 1'b0; idle = 1'b0; avail = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        q.push_back('{8'h60, "R1 reset"});
        @(negedge clk);
        rst_n = 1'b1;
        hold = 1'b1; idle = 1'b1; avail = 1'b0;
        step(0,0,0,0,0, 0,1,1, 0, "R1 idle after reset");
        // R2: each error sets its own bit and holds it.
        step(0,1,0,0,0, 0,1,1, 0, "R2 parity bit2");
        step(0,0,0,0,0, 0,1,1, 0, "R2 parity holds");
        step(0,0,1,0,0, 0,1,1, 0, "R2 framing bit3");
        step(0,0,0,1,0, 0,1,1, 0, "R2 break bit4");
        step(0,0,0,0,1, 0,1,1, 0, "R2 overrun bit1");
        // R3: the read cycle still shows 0x7E (checked above); cleared after the edge.
        step(0,0,0,0,0, 0,1,1, 1, "R3 clear on read");
        // R4: an event in the read cycle survives.
        step(0,0,1,0,0, 0,1,1, 0, "R4 framing before read");
        step(0,1,0,0,0, 0,1,1, 1, "R4 parity with read");
        // R5: FIFO-mode summary.
        step(1,0,0,0,0, 0,1,1, 1, "R5 enter fifo, clear");
        step(1,0,0,0,1, 0,1,1, 0, "R5 overrun alone no bit7");
        step(1,0,0,0,0, 0,1,1, 1, "R5 clear");
        step(1,0,0,1,0, 0,1,1, 0, "R5 break sets bit7");
        step(1,0,0,0,0, 0,1,1, 0, "R5 bit7 sticky");
        step(1,0,0,0,0, 0,1,1, 1, "R5 read clears bit7");
        step(1,0,1,0,0, 0,1,1, 0, "R5 framing sets bit7");
        // R6: character mode forces bit7 low.
        step(0,0,0,0,0, 0,1,1, 0, "R6 mode switch drops bit7");
        step(0,1,0,0,0, 0,1,1, 0, "R6 parity in char mode");
        step(0,0,0,0,0, 0,1,1, 1, "R6 clear");
        // R7 / R8: transmit-empty bits.
        step(0,0,0,0,0, 0,0,1, 0, "R7 hold busy");
        step(0,0,0,0,0, 0,1,0, 0, "R8 shift busy");
        step(1,0,0,0,0, 0,1,1, 0, "R8 both empty fifo mode");
        step(1,0,0,0,0, 0,0,0, 0, "R7 fifo busy");
        // R9 / R10: data-ready and read immunity.
        step(1,0,0,0,0, 1,0,0, 0, "R9 data ready");
        step(1,0,0,0,0, 1,0,0, 1, "R10 read keeps bits 0,5,6");
        step(1,0,0,0,0, 1,1,1, 1, "R10 read keeps empties");
        step(1,0,0,0,0, 0,1,1, 0, "R9 data gone");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule